// File: doc/BRIEF.md
# Serial Audio Output Serializer

This block turns 16-bit left/right PCM sample pairs into a three-wire serial audio stream: a bit clock, a channel-select clock and a serial data line, plus a flag that marks samples the upstream decoder could not repair. Every output is produced from one fast master clock (16.9344 MHz in the intended system). The bit clock is made by dividing that clock, so no second clock domain exists.

Software-facing configuration picks how many bit-clock periods make up one sample period (32, 48 or 64). It also sets the polarity of the channel clock, whether each word is sent most or least significant bit first, and normal or double speed. A producer offers one sample pair at a time with a valid/ready handshake. The block takes a pair, together with a fresh copy of the configuration, only at the start of a frame. If no pair is offered at that point, it sends a silent frame and reports the gap.

Top module: `saud_out`

## Requirements
- R1: At normal speed one bit-clock period lasts 12, 8 or 6 master cycles for `cfg_rate` codes 0 (32 slots per frame), 1 (48) and 2 (64). Code 3 behaves exactly like code 0.
- R2: With `cfg_double` high the bit-clock period is halved to 6, 4 or 3 master cycles. In each period the bit clock is low for the first D - floor(D/2) cycles and high for the remaining floor(D/2) cycles.
- R3: A frame has 2N bit slots, where N is 16, 24 or 32. The first N slots carry the left channel and the last N carry the right. `o_lrck` is 0 for left and 1 for right, and `cfg_lr_inv` = 1 inverts it.
- R4: In each half-frame the sample occupies the last 16 slots and the earlier slots are 0. The word goes out MSB first when `cfg_lsb_first` = 0 and LSB first when it is 1.
- R5: `o_sdata`, `o_lrck` and `o_err` change only together with a falling edge of `o_bck` and are stable at every rising edge. Every frame begins with the bit clock low.
- R6: `o_err` equals `in_err_left` for the whole left half-frame and `in_err_right` for the whole right half-frame of the pair that was accepted.
- R7: `in_ready` is high for exactly one master cycle at each frame start, and also in the first cycle after reset. A pair is taken when `in_valid` and `in_ready` are both high.
- R8: If `in_valid` is low when `in_ready` is high, the next frame sends all-zero data with `o_err` low and `o_underrun` high. `o_underrun` returns to 0 at the next frame that takes a pair.
- R9: The configuration inputs are sampled only when `in_ready` is high. Changing them during a frame has no effect on that frame.
- R10: While reset is held, all serial outputs and `o_underrun` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 2 | Slots per frame: 0=32, 1=48, 2=64, 3=32 |
| cfg_lr_inv | input | 1 | Invert the channel clock polarity |
| cfg_lsb_first | input | 1 | Send each word LSB first |
| cfg_double | input | 1 | Double-speed bit clock |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Pair taken this cycle (frame start) |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| in_err_left | input | 1 | Left sample is uncorrectable |
| in_err_right | input | 1 | Right sample is uncorrectable |
| o_bck | output | 1 | Bit clock |
| o_lrck | output | 1 | Channel clock |
| o_sdata | output | 1 | Serial data |
| o_err | output | 1 | Error flag aligned with the current channel |
| o_underrun | output | 1 | Current frame is silent because no pair was offered |

## Verification
The bench targets the odd divisor of three master cycles at double speed, where a mistake in the high/low split would move the data transition onto the rising edge or stretch the period. It also targets the three zero-padding lengths: a design that places the word at the start of the half-frame, or miscounts the padding for 48 slots, sends shifted bits. Configuration is changed in the middle of every frame, so a design that does not hold the latched settings would switch rate or bit order partway through a frame. Silent frames sit between data frames, which exposes stale data, a stale error flag, or an underrun flag that does not clear.

// File: rtl/saud_pkg.sv
package saud_pkg;

   // frame slot counter width: covers up to 64 slots per frame
   localparam int SLOT_W = 6;

   typedef enum logic [1:0] {
      RATE_32  = 2'd0,
      RATE_48  = 2'd1,
      RATE_64  = 2'd2,
      RATE_RSV = 2'd3
   } rate_e;

   // bit slots in one channel half-frame
   function automatic logic [SLOT_W-1:0] half_slots(input rate_e r);
      case (r)
         RATE_48: half_slots = SLOT_W'(24);
         RATE_64: half_slots = SLOT_W'(32);
         default: half_slots = SLOT_W'(16);
      endcase
   endfunction

endpackage

// File: rtl/saud_bitclk.sv
module saud_bitclk
   import saud_pkg::*;
#(
   parameter int DIV32 = 12,
   parameter int DIV48 = 8,
   parameter int DIV64 = 6,
   localparam int DIV_W = $clog2(DIV32 + 1)
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  rate_e rate,
   input  logic  dbl,
   output logic  slot_end,
   output logic  bck_level
);

   logic [DIV_W-1:0] d_base;
   logic [DIV_W-1:0] d_sel;
   logic [DIV_W-1:0] low_len;
   logic [DIV_W-1:0] cnt_q;

   // master cycles per bit slot for the latched configuration
   always_comb begin
      case (rate)
         RATE_48: d_base = DIV_W'(DIV48);
         RATE_64: d_base = DIV_W'(DIV64);
         default: d_base = DIV_W'(DIV32);
      endcase
      d_sel   = dbl ? (d_base >> 1) : d_base;
      low_len = d_sel - (d_sel >> 1);
   end

   assign slot_end  = run && (cnt_q == d_sel - DIV_W'(1));
   assign bck_level = run && (cnt_q >= low_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || slot_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/saud_sequencer.sv
module saud_sequencer
   import saud_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slot_end,
   input  rate_e               cfg_rate_in,
   input  logic                cfg_inv_in,
   input  logic                cfg_lsb_in,
   input  logic                cfg_dbl_in,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                in_err_left,
   input  logic                in_err_right,
   output logic                load,
   output logic                run,
   output logic [SLOT_W-1:0]   slot,
   output rate_e               rate_q,
   output logic                inv_q,
   output logic                lsb_q,
   output logic                dbl_q,
   output logic [SAMPLE_W-1:0] word_l,
   output logic [SAMPLE_W-1:0] word_r,
   output logic                err_l,
   output logic                err_r,
   output logic                underrun
);

   logic [SLOT_W-1:0] half_n;
   logic [SLOT_W-1:0] last_slot;

   assign half_n    = half_slots(rate_q);
   assign last_slot = (half_n << 1) - SLOT_W'(1);

   // frame start: first cycle out of reset, or end of the final slot
   assign load = !run || (slot_end && (slot == last_slot));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run      <= 1'b0;
         slot     <= '0;
         rate_q   <= RATE_32;
         inv_q    <= 1'b0;
         lsb_q    <= 1'b0;
         dbl_q    <= 1'b0;
         word_l   <= '0;
         word_r   <= '0;
         err_l    <= 1'b0;
         err_r    <= 1'b0;
         underrun <= 1'b0;
      end else if (load) begin
         run    <= 1'b1;
         slot   <= '0;
         rate_q <= cfg_rate_in;
         inv_q  <= cfg_inv_in;
         lsb_q  <= cfg_lsb_in;
         dbl_q  <= cfg_dbl_in;
         if (in_valid) begin
            word_l   <= in_left;
            word_r   <= in_right;
            err_l    <= in_err_left;
            err_r    <= in_err_right;
            underrun <= 1'b0;
         end else begin
            word_l   <= '0;
            word_r   <= '0;
            err_l    <= 1'b0;
            err_r    <= 1'b0;
            underrun <= 1'b1;
         end
      end else if (slot_end) begin
         slot <= slot + SLOT_W'(1);
      end
   end

endmodule

// File: rtl/saud_serializer.sv
module saud_serializer
   import saud_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   localparam int IDX_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                bck_level,
   input  logic [SLOT_W-1:0]   slot,
   input  rate_e               rate,
   input  logic                inv,
   input  logic                lsb,
   input  logic [SAMPLE_W-1:0] word_l,
   input  logic [SAMPLE_W-1:0] word_r,
   input  logic                err_l,
   input  logic                err_r,
   output logic                o_bck,
   output logic                o_lrck,
   output logic                o_sdata,
   output logic                o_err
);

   logic [SLOT_W-1:0]   half_n;
   logic [SLOT_W-1:0]   pos;
   logic [SLOT_W-1:0]   lead;
   logic [SLOT_W-1:0]   k;
   logic [IDX_W-1:0]    idx;
   logic                right;
   logic                in_data;
   logic [SAMPLE_W-1:0] word;
   logic [SAMPLE_W-1:0] word_rev;
   logic [SAMPLE_W-1:0] ordered;
   logic                bit_nxt;

   always_comb begin
      half_n  = half_slots(rate);
      right   = (slot >= half_n);
      pos     = right ? (slot - half_n) : slot;
      lead    = half_n - SLOT_W'(SAMPLE_W);
      in_data = (pos >= lead);
      k       = pos - lead;
      idx     = IDX_W'(SLOT_W'(SAMPLE_W - 1) - k);
      word    = right ? word_r : word_l;
   end

   // bit-reversed copy serves the LSB-first order
   for (genvar i = 0; i < SAMPLE_W; i++) begin : g_rev
      assign word_rev[i] = word[SAMPLE_W-1-i];
   end

   assign ordered = lsb ? word_rev : word;
   assign bit_nxt = in_data && ordered[idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_bck   <= 1'b0;
         o_lrck  <= 1'b0;
         o_sdata <= 1'b0;
         o_err   <= 1'b0;
      end else begin
         o_bck   <= bck_level;
         o_lrck  <= run && (right ^ inv);
         o_sdata <= run && bit_nxt;
         o_err   <= run && (right ? err_r : err_l);
      end
   end

endmodule

// File: rtl/saud_out.sv
module saud_out
   import saud_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int DIV32    = 12,
   parameter int DIV48    = 8,
   parameter int DIV64    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          cfg_rate,
   input  logic                cfg_lr_inv,
   input  logic                cfg_lsb_first,
   input  logic                cfg_double,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                in_err_left,
   input  logic                in_err_right,
   output logic                o_bck,
   output logic                o_lrck,
   output logic                o_sdata,
   output logic                o_err,
   output logic                o_underrun
);

   // elaboration checks on the parameter set
   if (SAMPLE_W < 2 || SAMPLE_W > 16) begin : g_bad_width
      $error("SAMPLE_W must fit the shortest half-frame of 16 slots");
   end
   if ((DIV32 % 2) != 0 || (DIV48 % 2) != 0 || (DIV64 % 2) != 0) begin : g_bad_even
      $error("bit-clock divisors must be even so double speed can halve them");
   end
   if (DIV64 < 6 || DIV48 < DIV64 || DIV32 < DIV48) begin : g_bad_order
      $error("divisors must satisfy DIV32 >= DIV48 >= DIV64 >= 6");
   end

   logic                run;
   logic                load;
   logic                slot_end;
   logic                bck_level;
   logic [SLOT_W-1:0]   slot;
   rate_e               rate_q;
   logic                inv_q;
   logic                lsb_q;
   logic                dbl_q;
   logic [SAMPLE_W-1:0] word_l;
   logic [SAMPLE_W-1:0] word_r;
   logic                err_l;
   logic                err_r;

   assign in_ready = load;

   saud_sequencer #(.SAMPLE_W(SAMPLE_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .slot_end     (slot_end),
      .cfg_rate_in  (rate_e'(cfg_rate)),
      .cfg_inv_in   (cfg_lr_inv),
      .cfg_lsb_in   (cfg_lsb_first),
      .cfg_dbl_in   (cfg_double),
      .in_valid     (in_valid),
      .in_left      (in_left),
      .in_right     (in_right),
      .in_err_left  (in_err_left),
      .in_err_right (in_err_right),
      .load         (load),
      .run          (run),
      .slot         (slot),
      .rate_q       (rate_q),
      .inv_q        (inv_q),
      .lsb_q        (lsb_q),
      .dbl_q        (dbl_q),
      .word_l       (word_l),
      .word_r       (word_r),
      .err_l        (err_l),
      .err_r        (err_r),
      .underrun     (o_underrun)
   );

   saud_bitclk #(
      .DIV32 (DIV32),
      .DIV48 (DIV48),
      .DIV64 (DIV64)
   ) u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .rate      (rate_q),
      .dbl       (dbl_q),
      .slot_end  (slot_end),
      .bck_level (bck_level)
   );

   saud_serializer #(.SAMPLE_W(SAMPLE_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .bck_level (bck_level),
      .slot      (slot),
      .rate      (rate_q),
      .inv       (inv_q),
      .lsb       (lsb_q),
      .word_l    (word_l),
      .word_r    (word_r),
      .err_l     (err_l),
      .err_r     (err_r),
      .o_bck     (o_bck),
      .o_lrck    (o_lrck),
      .o_sdata   (o_sdata),
      .o_err     (o_err)
   );

endmodule

// File: rtl/saud_out_chk.sv
module saud_out_chk (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic o_bck,
   input logic o_lrck,
   input logic o_sdata,
   input logic o_err,
   input logic o_underrun
);

   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready); // R7

   AST_FRAME_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> ##1 !o_bck); // R5

   AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_bck) |-> ($stable(o_sdata) && $stable(o_lrck) && $stable(o_err))); // R5

   AST_UNDERRUN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (o_underrun && $past(o_underrun)) |-> (!o_sdata && !o_err)); // R8

endmodule

bind saud_out saud_out_chk u_chk (.*);

// File: tb/saud_out_tb.sv
module saud_out_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NFRAMES    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_rate = 2'd0;
   logic        cfg_lr_inv = 1'b0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_double = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] in_left = '0;
   logic [15:0] in_right = '0;
   logic        in_err_left = 1'b0;
   logic        in_err_right = 1'b0;
   logic        o_bck, o_lrck, o_sdata, o_err, o_underrun;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   typedef struct {
      int          rate;
      bit          dbl;
      bit          inv;
      bit          lsb;
      logic [15:0] l;
      logic [15:0] r;
      bit          el;
      bit          er;
      bit          und;
   } item_t;

   item_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   saud_out u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_rate     (cfg_rate),
      .cfg_lr_inv   (cfg_lr_inv),
      .cfg_lsb_first(cfg_lsb_first),
      .cfg_double   (cfg_double),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .in_left      (in_left),
      .in_right     (in_right),
      .in_err_left  (in_err_left),
      .in_err_right (in_err_right),
      .o_bck        (o_bck),
      .o_lrck       (o_lrck),
      .o_sdata      (o_sdata),
      .o_err        (o_err),
      .o_underrun   (o_underrun)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   // driver: offer one frame (or a gap) and push the expected item
   task automatic send_frame(input int rc, input bit dbl, input bit inv, input bit lsb,
                             input logic [15:0] l, input logic [15:0] r,
                             input bit el, input bit er, input bit gap);
      item_t it;
      cfg_rate      = 2'(rc);
      cfg_double    = dbl;
      cfg_lr_inv    = inv;
      cfg_lsb_first = lsb;
      in_valid      = !gap;
      in_left       = gap ? 16'h0 : l;
      in_right      = gap ? 16'h0 : r;
      in_err_left   = gap ? 1'b0 : el;
      in_err_right  = gap ? 1'b0 : er;
      while (!(in_ready && rst_n)) @(negedge clk);
      @(posedge clk);
      #1;
      it.rate = (rc == 3) ? 0 : rc;   // R1 code 3 acts as 32 slots
      it.dbl  = dbl;
      it.inv  = inv;
      it.lsb  = lsb;
      it.l    = gap ? 16'h0 : l;
      it.r    = gap ? 16'h0 : r;
      it.el   = gap ? 1'b0 : el;
      it.er   = gap ? 1'b0 : er;
      it.und  = gap;
      sb.push_back(it);
      @(negedge clk);
      check(in_ready == 1'b0, "R7 ready single cycle", int'(in_ready), 0);
   endtask

   // monitor helper: wait for the next bit-clock rise seen at negedges
   task automatic next_rise(output int gap, output bit stable_ok);
      int   n = 0;
      logic pb, pd, pl;
      do begin
         pb = o_bck;
         pd = o_sdata;
         pl = o_lrck;
         @(negedge clk);
         n++;
      end while (!(o_bck && !pb));
      gap       = n;
      stable_ok = (pd === o_sdata) && (pl === o_lrck);
   endtask

   // monitor / scoreboard
   initial begin
      item_t it;
      wait (rst_n === 1'b1);
      for (int f = 0; f < NFRAMES; f++) begin
         int n_half, d, lead;
         for (int s = 0; s < 0 + 1; s++) begin end
         n_half = (it.rate == 0) ? 16 : 16;
         for (int s = 0; s < 1; s++) begin end
         begin
            int gap;
            bit st;
            next_rise(gap, st);
            if (sb.size() == 0) begin
               check(1'b0, "R7 frame without accepted item", 0, 1);
               finish_run();
            end
            it     = sb.pop_front();
            n_half = (it.rate == 0) ? 16 : (it.rate == 1) ? 24 : 32;
            d      = (it.rate == 0) ? 12 : (it.rate == 1) ? 8 : 6;
            if (it.dbl) d = d / 2;
            lead   = n_half - 16;
            for (int s = 0; s < 2 * n_half; s++) begin
               bit   right;
               int   pos;
               logic [15:0] w;
               logic exp_d, exp_e, exp_l;
               if (s != 0) next_rise(gap, st);
               right = (s >= n_half);
               pos   = right ? s - n_half : s;
               w     = right ? it.r : it.l;
               if (pos < lead) exp_d = 1'b0;
               else if (it.lsb) exp_d = w[pos - lead];
               else exp_d = w[15 - (pos - lead)];
               exp_l = right ^ it.inv;
               exp_e = right ? it.er : it.el;
               if (s != 0)
                  check(gap == d, it.dbl ? "R2 bit-clock period" : "R1 bit-clock period", gap, d);
               check(st, "R5 data stable at rise", int'(st), 1);
               check(o_lrck === exp_l, "R3 lrck level", int'(o_lrck), int'(exp_l));
               check(o_sdata === exp_d, "R4 R9 data bit", int'(o_sdata), int'(exp_d));
               check(o_err === exp_e, "R6 error flag", int'(o_err), int'(exp_e));
               if (s == n_half)
                  check(o_underrun === it.und, "R8 underrun flag", int'(o_underrun), int'(it.und));
            end
         end
      end
      finish_run();
   end

   // stimulus
   initial begin
      repeat (3) @(negedge clk);
      check(o_bck === 1'b0 && o_lrck === 1'b0 && o_sdata === 1'b0 && o_err === 1'b0,
            "R10 serial outputs in reset", int'({o_bck, o_lrck, o_sdata, o_err}), 0);
      check(o_underrun === 1'b0, "R10 underrun in reset", int'(o_underrun), 0);
      check(in_ready === 1'b1, "R10 ready in reset", int'(in_ready), 1);
      rst_n = 1'b1;
      send_frame(0, 0, 0, 0, 16'hA5C3, 16'h1234, 0, 1, 0);
      send_frame(1, 0, 1, 1, 16'h8001, 16'h7FFE, 1, 0, 0);
      send_frame(2, 0, 0, 0, 16'hFFFF, 16'h0000, 1, 1, 0);
      send_frame(0, 0, 0, 0, 16'h0000, 16'h0000, 0, 0, 1);   // R8 gap
      send_frame(0, 1, 0, 1, 16'hC0DE, 16'hBEEF, 0, 0, 0);
      send_frame(1, 1, 1, 0, 16'h0001, 16'h8000, 0, 1, 0);
      send_frame(2, 1, 1, 1, 16'h1357, 16'h9BDF, 1, 0, 0);   // R2 divisor 3
      send_frame(3, 0, 0, 0, 16'h5A5A, 16'hA5A5, 0, 0, 0);   // R1 code 3
      send_frame(2, 1, 1, 0, 16'h0000, 16'h0000, 0, 0, 1);   // R8 gap
      send_frame(1, 0, 0, 1, 16'hF00F, 16'h0FF0, 1, 1, 0);
      // R9: disturb configuration while the last frame is in flight
      cfg_rate      = 2'd2;
      cfg_double    = 1'b1;
      cfg_lsb_first = 1'b0;
      cfg_lr_inv    = 1'b1;
      in_valid      = 1'b0;
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

endmodule